// File: doc/BRIEF.md
# Dual-Port Hardware Spinlock Bank

This block holds a set of single-bit lock flags that two processor ports share through one register window. Each port reads a lock's address to make an atomic test-and-set attempt. The read acquires the lock if it is free and tells the port whether the attempt won. A write to the same address frees the lock, whatever the write data. A status word at a separate address shows which locks are held and changes nothing.

Each port has a plain register interface: byte address, read strobe, write strobe, write data and read data. Read data is registered and appears one clock after the read strobe. When both ports act in the same cycle, the outcome follows fixed rules, so software can rely on it.

Top module: `spinlock_bank`

## Requirements
- R1: The bank holds 32 locks. Lock n sits at byte address 0x100 + 4*n, and read data for a strobe sampled at one rising edge is valid after that edge.
- R2: A read of a free lock n marks it held and returns a word with only bit n set.
- R3: A read of a held lock returns zero, and the lock stays held.
- R4: A write strobe to a lock's address frees that lock, for any write data value.
- R5: A read of address 0x000 returns the status word. Bit n is 1 when lock n is held. The value is taken before that cycle's acquires and releases, and the read alters no lock.
- R6: When both ports read the same free lock in one cycle, port 0 gets the one-hot word and port 1 gets zero.
- R7: When one port frees a lock in the same cycle that the other port reads it, the release applies first, so the reader acquires the lock and gets the one-hot word.
- R8: After the synchronous active-high reset, every lock is free and both read data outputs are zero.
- R9: Both ports act on the same locks. A lock taken by one port reads as busy from the other port, and either port may free it.
- R10: A read of any address other than a lock or the status word returns zero. A write to such an address, or to the status word, changes no lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_addr | input | 12 | Port 0 byte address |
| p0_rd | input | 1 | Port 0 read strobe (acquire or status read) |
| p0_wr | input | 1 | Port 0 write strobe (release) |
| p0_wdata | input | 32 | Port 0 write data (ignored by the locks) |
| p0_rdata | output | 32 | Port 0 registered read data |
| p1_addr | input | 12 | Port 1 byte address |
| p1_rd | input | 1 | Port 1 read strobe |
| p1_wr | input | 1 | Port 1 write strobe |
| p1_wdata | input | 32 | Port 1 write data (ignored by the locks) |
| p1_rdata | output | 32 | Port 1 registered read data |

## Verification
Two cases can fall in the same cycle: an acquire by one port against an acquire by the other port, and an acquire by one port against a release by the other port. The bench drives both ports on the same clock edge at lock 31, once with two reads and once with a write on port 0 and a read on port 1. A reference model applies releases first and then gives port 0 priority, and the scoreboard compares each port's read data against it. A status read placed in the same cycle as a release shows that status reports the state from before the update.

// File: rtl/spinlock_pkg.sv
package spinlock_pkg;
  localparam int DATA_W = 32;
  typedef logic [DATA_W-1:0] word_t;

  // Per-port decoded request kinds
  typedef enum logic [1:0] {
    REQ_NONE   = 2'd0,
    REQ_LOCK   = 2'd1,
    REQ_STATUS = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/spinlock_decode.sv
module spinlock_decode #(
  parameter int ADDR_W      = 12,
  parameter int NUM_LOCKS   = 32,
  parameter int LOCK_BASE   = 'h100,
  parameter int STATUS_ADDR = 'h000
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd,
  input  logic                 wr,
  output logic [NUM_LOCKS-1:0] acq_vec,
  output logic [NUM_LOCKS-1:0] rel_vec,
  output logic                 stat_rd
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(LOCK_BASE);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NUM_LOCKS);
  localparam logic [ADDR_W-1:0] STAT = ADDR_W'(STATUS_ADDR);

  logic [ADDR_W-1:0]    off;
  logic                 in_win;
  logic [NUM_LOCKS-1:0] sel;

  assign off    = addr - BASE;
  assign in_win = (addr >= BASE) && (off < SPAN);

  for (genvar n = 0; n < NUM_LOCKS; n++) begin : g_sel
    assign sel[n] = in_win && (off == ADDR_W'(4 * n));
  end

  assign acq_vec = rd ? sel : '0;
  assign rel_vec = wr ? sel : '0;
  assign stat_rd = rd && (addr == STAT);
endmodule

// File: rtl/spinlock_arbiter.sv
module spinlock_arbiter #(
  parameter int NUM_LOCKS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LOCKS-1:0] acq0,
  input  logic [NUM_LOCKS-1:0] acq1,
  input  logic [NUM_LOCKS-1:0] rel0,
  input  logic [NUM_LOCKS-1:0] rel1,
  output logic [NUM_LOCKS-1:0] grant0,
  output logic [NUM_LOCKS-1:0] grant1,
  output logic [NUM_LOCKS-1:0] lock_q
);
  logic [NUM_LOCKS-1:0] after_rel;

  // Releases resolve first, then port 0 ahead of port 1
  assign after_rel = lock_q & ~(rel0 | rel1);
  assign grant0    = acq0 & ~after_rel;
  assign grant1    = acq1 & ~after_rel & ~grant0;

  always_ff @(posedge clk) begin
    if (rst) lock_q <= '0;
    else     lock_q <= after_rel | grant0 | grant1;
  end
endmodule

// File: rtl/spinlock_readout.sv
module spinlock_readout
  import spinlock_pkg::*;
#(
  parameter int NUM_LOCKS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stat_rd,
  input  logic [NUM_LOCKS-1:0] grant,
  input  logic [NUM_LOCKS-1:0] status,
  output word_t                rdata
);
  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (stat_rd) rdata <= DATA_W'(status);
    else              rdata <= DATA_W'(grant);
  end
endmodule

// File: rtl/spinlock_bank.sv
module spinlock_bank
  import spinlock_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_LOCKS   = 32,
  parameter int LOCK_BASE   = 'h100,
  parameter int STATUS_ADDR = 'h000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic              p0_rd,
  input  logic              p0_wr,
  input  logic [31:0]       p0_wdata,
  output logic [31:0]       p0_rdata,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic              p1_rd,
  input  logic              p1_wr,
  input  logic [31:0]       p1_wdata,
  output logic [31:0]       p1_rdata
);
  localparam int NPORT = 2;

  logic [ADDR_W-1:0]    addr_a [NPORT];
  logic                 rd_a   [NPORT];
  logic                 wr_a   [NPORT];
  logic [NUM_LOCKS-1:0] acq_a  [NPORT];
  logic [NUM_LOCKS-1:0] rel_a  [NPORT];
  logic                 stat_a [NPORT];
  logic [NUM_LOCKS-1:0] gnt_a  [NPORT];
  word_t                rdat_a [NPORT];
  logic [NUM_LOCKS-1:0] lock_q;
  logic [63:0]          wdata_unused;

  // Write data carries no meaning for a release
  assign wdata_unused = {p0_wdata, p1_wdata};

  assign addr_a[0] = p0_addr;
  assign addr_a[1] = p1_addr;
  assign rd_a[0]   = p0_rd;
  assign rd_a[1]   = p1_rd;
  assign wr_a[0]   = p0_wr;
  assign wr_a[1]   = p1_wr;
  assign p0_rdata  = rdat_a[0];
  assign p1_rdata  = rdat_a[1];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    spinlock_decode #(
      .ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS),
      .LOCK_BASE(LOCK_BASE), .STATUS_ADDR(STATUS_ADDR)
    ) u_dec (
      .addr(addr_a[p]), .rd(rd_a[p]), .wr(wr_a[p]),
      .acq_vec(acq_a[p]), .rel_vec(rel_a[p]), .stat_rd(stat_a[p])
    );

    spinlock_readout #(.NUM_LOCKS(NUM_LOCKS)) u_rd (
      .clk(clk), .rst(rst), .stat_rd(stat_a[p]),
      .grant(gnt_a[p]), .status(lock_q), .rdata(rdat_a[p])
    );
  end

  spinlock_arbiter #(.NUM_LOCKS(NUM_LOCKS)) u_arb (
    .clk(clk), .rst(rst),
    .acq0(acq_a[0]), .acq1(acq_a[1]),
    .rel0(rel_a[0]), .rel1(rel_a[1]),
    .grant0(gnt_a[0]), .grant1(gnt_a[1]),
    .lock_q(lock_q)
  );
endmodule

// File: rtl/spinlock_bank_chk.sv
module spinlock_bank_chk #(
  parameter int ADDR_W    = 12,
  parameter int NUM_LOCKS = 32,
  parameter int LOCK_BASE = 'h100
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    p0_addr,
  input logic                 p0_rd,
  input logic                 p0_wr,
  input logic [ADDR_W-1:0]    p1_addr,
  input logic                 p1_rd,
  input logic                 p1_wr,
  input logic [31:0]          p0_rdata,
  input logic [31:0]          p1_rdata,
  input logic [NUM_LOCKS-1:0] lock_q
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(LOCK_BASE);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NUM_LOCKS);

  logic [ADDR_W-1:0] off0, off1;
  logic              hit0, hit1;
  logic [31:0]       oh1;

  assign off0 = p0_addr - BASE;
  assign off1 = p1_addr - BASE;
  assign hit0 = (p0_addr >= BASE) && (off0 < SPAN) && (off0[1:0] == 2'b00);
  assign hit1 = (p1_addr >= BASE) && (off1 < SPAN) && (off1[1:0] == 2'b00);
  assign oh1  = 32'(1) << off1[ADDR_W-1:2];

  assert_reset_free_R8: assert property (@(posedge clk)
    rst |=> (lock_q == '0) && (p0_rdata == '0) && (p1_rdata == '0));

  assert_held_stays_R3: assert property (@(posedge clk) disable iff (rst)
    (!p0_wr && !p1_wr) |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  assert_win_marks_held_R2: assert property (@(posedge clk) disable iff (rst)
    (p0_rd && hit0) |=> (p0_rdata == '0) ||
                        ((p0_rdata & 32'(lock_q)) == p0_rdata));

  assert_port0_priority_R6: assert property (@(posedge clk) disable iff (rst)
    (p0_rd && p1_rd && hit0 && hit1 && (p0_addr == p1_addr)) |=> (p1_rdata == '0));

  assert_release_first_R7: assert property (@(posedge clk) disable iff (rst)
    (p0_wr && p1_rd && hit1 && (p0_addr == p1_addr) && !p0_rd) |=> (p1_rdata == $past(oh1)));

  assert_status_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!p0_wr && !p1_wr && !(p0_rd && hit0) && !(p1_rd && hit1)) |=> $stable(lock_q));

  assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    (p0_rd && hit0) |=> $onehot0(p0_rdata));
endmodule

bind spinlock_bank spinlock_bank_chk #(
  .ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS), .LOCK_BASE(LOCK_BASE)
) u_chk (
  .clk(clk), .rst(rst),
  .p0_addr(p0_addr), .p0_rd(p0_rd), .p0_wr(p0_wr),
  .p1_addr(p1_addr), .p1_rd(p1_rd), .p1_wr(p1_wr),
  .p0_rdata(p0_rdata), .p1_rdata(p1_rdata), .lock_q(lock_q)
);

// File: tb/sim_spinlock_bank.sv
`timescale 1ns/1ps
module sim_spinlock_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] p0_addr = '0, p1_addr = '0;
  logic        p0_rd = 1'b0, p0_wr = 1'b0, p1_rd = 1'b0, p1_wr = 1'b0;
  logic [31:0] p0_wdata = '0, p1_wdata = '0;
  logic [31:0] p0_rdata, p1_rdata;

  typedef struct {
    int          port;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [31:0] model = '0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  spinlock_bank u0 (
    .clk(clk), .rst(rst),
    .p0_addr(p0_addr), .p0_rd(p0_rd), .p0_wr(p0_wr), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
    .p1_addr(p1_addr), .p1_rd(p1_rd), .p1_wr(p1_wr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata)
  );

  function automatic int lock_of(logic [11:0] a);
    if (a >= 12'h100 && a < 12'h180 && a[1:0] == 2'b00) return int'((a - 12'h100) >> 2);
    return -1;
  endfunction

  function automatic logic [11:0] la(int n);
    return 12'(32'h100 + 4 * n);
  endfunction

  // Drive one cycle on both ports and queue the modelled results
  task automatic cyc(input logic [11:0] a0, input logic r0, input logic w0, input logic [31:0] d0,
                     input logic [11:0] a1, input logic r1, input logic w1, input logic [31:0] d1,
                     input string tag);
    logic [31:0] rel, after, e0, e1;
    int n0, n1;
    @(negedge clk);
    p0_addr = a0; p0_rd = r0; p0_wr = w0; p0_wdata = d0;
    p1_addr = a1; p1_rd = r1; p1_wr = w1; p1_wdata = d1;
    n0 = lock_of(a0);
    n1 = lock_of(a1);
    rel = '0;
    if (w0 && n0 >= 0) rel[n0] = 1'b1;
    if (w1 && n1 >= 0) rel[n1] = 1'b1;
    after = model & ~rel;
    e0 = '0; e1 = '0;
    if (r0 && a0 == 12'h000) e0 = model;
    if (r1 && a1 == 12'h000) e1 = model;
    if (r0 && n0 >= 0 && !after[n0]) begin e0[n0] = 1'b1; after[n0] = 1'b1; end
    if (r1 && n1 >= 0 && !after[n1]) begin e1[n1] = 1'b1; after[n1] = 1'b1; end
    model = after;
    if (r0) sb.push_back('{0, e0, tag});
    if (r1) sb.push_back('{1, e1, tag});
  endtask

  task automatic idle();
    cyc(12'h0, 1'b0, 1'b0, '0, 12'h0, 1'b0, 1'b0, '0, "idle");
  endtask

  // Monitor: results are valid just after the edge that sampled the strobe
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = sb.pop_front();
        got = (it.port == 0) ? p0_rdata : p1_rdata;
        n_chk++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s port%0d actual=%h expected=%h", it.tag, it.port, got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R8: reset state, both outputs zero then status zero
    n_chk++;
    if (p0_rdata !== '0 || p1_rdata !== '0) begin
      n_fail++;
      $display("FAIL R8 rdata actual=%h/%h expected=0", p0_rdata, p1_rdata);
    end
    cyc(12'h000, 1, 0, '0, 12'h000, 1, 0, '0, "R8 status");
    // R2 / R1: acquire lock 3
    cyc(la(3), 1, 0, '0, 12'h0, 0, 0, '0, "R2 acquire");
    // R3: re-read held lock; R5/R9 status from other port
    cyc(la(3), 1, 0, '0, 12'h000, 1, 0, '0, "R3 held");
    // R9: other port sees it busy
    cyc(12'h0, 0, 0, '0, la(3), 1, 0, '0, "R9 shared busy");
    // R4/R9: port 1 releases; R5: same-cycle status shows old value
    cyc(12'h000, 1, 0, '0, la(3), 0, 1, 32'h0, "R5 pre-update status");
    cyc(12'h000, 1, 0, '0, 12'h0, 0, 0, '0, "R4 released");
    // R6: both read free lock 31
    cyc(la(31), 1, 0, '0, la(31), 1, 0, '0, "R6 priority");
    // R7: port 0 frees, port 1 acquires same cycle
    cyc(la(31), 0, 1, 32'hdead_beef, la(31), 1, 0, '0, "R7 release first");
    cyc(12'h000, 1, 0, '0, 12'h0, 0, 0, '0, "R7 status");
    // R1: port 1 takes every lock
    for (int n = 0; n < 32; n++) cyc(12'h0, 0, 0, '0, la(n), 1, 0, '0, "R1 sweep");
    cyc(12'h000, 1, 0, '0, 12'h000, 1, 0, '0, "R1 all held");
    // R4: port 0 frees all with varying data
    for (int n = 0; n < 32; n++) cyc(la(n), 0, 1, 32'(n * 32'h0101_0107), 12'h0, 0, 0, '0, "R4 any data");
    cyc(12'h000, 1, 0, '0, 12'h0, 0, 0, '0, "R4 all free");
    // R10: unmapped and misaligned accesses
    cyc(la(5), 1, 0, '0, 12'h0, 0, 0, '0, "R10 setup");
    cyc(12'h102, 1, 0, '0, 12'h200, 1, 0, '0, "R10 unmapped read");
    cyc(12'h000, 0, 1, 32'h0, 12'h106, 0, 1, '0, "R10 writes");
    cyc(12'h000, 1, 0, '0, 12'h0FC, 1, 0, '0, "R10 state kept");
    idle();
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule